// File: doc/BRIEF.md
# Serial Flag Offset Register Port

This block keeps the two thresholds a FIFO's programmable flag logic compares against: the empty offset, which sets the almost-empty threshold, and the full offset, which sets the almost-full threshold. Each offset is W bits wide, where W = log2(DEPTH). While reset is held, both offsets take the same default value. Two select inputs choose that value from a table of four.

After reset, software-side logic can replace the offsets over a serial port clocked by a shift clock. With the load enable low, each rising edge shifts one bit into a single 2·W-bit chain. The chain starts at the empty offset LSB and ends at the full offset MSB. The new pair replaces the active pair only on the edge that takes the last bit. While a chain is incomplete, the valid output is low and the old offsets stay in force. With the readback enable low, the active chain comes out one bit per edge in the same order. Every readback session starts again at the first bit.

Two state machines control the block. The load machine has two states. LD_ARMED means the offsets are valid and no chain is open. LD_FILLING means a partial chain is held. Its transitions are: start (first load bit, ARMED to FILLING), advance (FILLING to FILLING) and commit (last bit, FILLING to ARMED). The readback machine has two states, RB_IDLE and RB_STREAM. Its transitions are: open (read edge from IDLE, which sends bit 0), stream (read edge in STREAM, which sends the next bit) and close (any edge without a read, back to IDLE).

Top module: `ofs_serial_port`

## Requirements
- R1: A synchronous reset loads both offsets with the default chosen by `dflt_sel`: 2'b11 gives 255, 2'b01 gives 127, 2'b10 gives 63 and 2'b00 gives 7. After reset, `ofs_valid` is 1 and `ser_out` is 0.
- R2: A load edge is a rising edge with `load_n`=0 and `rdbk_n`=1. The first bit shifted in becomes bit 0 of `empty_ofs`. Bit W becomes bit 0 of `full_ofs`. The 2·W-th bit becomes the MSB of `full_ofs`.
- R3: The load edge that opens a new chain drives `ofs_valid` to 0. The load edge that takes the 2·W-th bit drives it to 1, and both offsets update on that same edge.
- R4: While a chain is incomplete, `empty_ofs` and `full_ofs` keep their previous values. A load that pauses and later resumes completes once the total number of bits reaches 2·W.
- R5: The offsets can be reprogrammed any number of times after reset. Each complete chain replaces both offsets. Load edges after a commit open a new chain.
- R6: A read edge is a rising edge with `load_n`=1 and `rdbk_n`=0. On each read edge, `ser_out` shows the next bit of the active chain, in the load order: empty LSB first, full MSB last. Read edges never change the offsets or `ofs_valid`.
- R7: Any edge that is not a read edge ends the readback session. The next read edge then shows bit 0 (the empty offset LSB), wherever the earlier session stopped.
- R8: An edge with both `load_n` and `rdbk_n` low performs neither operation. The offsets, `ofs_valid` and `ser_out` hold, and the number of bits in an open chain does not change.
- R9: A readback that runs past 2·W read edges wraps around to bit 0 and continues.
- R10: The extreme offset values 0 and DEPTH−1 load and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dflt_sel | input | 2 | Default offset select, sampled while reset is held |
| load_n | input | 1 | Serial load enable, active low |
| ser_in | input | 1 | Serial data into the offset chain |
| rdbk_n | input | 1 | Serial readback enable, active low |
| ser_out | output | 1 | Serial data out of the active chain |
| empty_ofs | output | W | Active empty offset |
| full_ofs | output | W | Active full offset |
| ofs_valid | output | 1 | Offsets are complete and valid for the flag logic |

## Verification
A load and a readback can both be requested on the same shift-clock edge, because both enables may be low together. The random stimulus drives that conflict often. The directed tests also place it in the middle of an open chain and in the middle of a readback session. The bench model holds every output on a conflict edge, keeps the chain count unchanged and ends the read session. The next read bit must therefore be bit 0, and the resumed load must commit after exactly the remaining number of bits.

// File: rtl/ofs_serial_port_pkg.sv
package ofs_serial_port_pkg;

    typedef enum logic {
        LD_ARMED,
        LD_FILLING
    } ld_state_t;

    typedef enum logic {
        RB_IDLE,
        RB_STREAM
    } rb_state_t;

    // Default offset code for each select value.
    function automatic logic [7:0] dflt_code(input logic [1:0] sel);
        logic [7:0] code;
        unique case (sel)
            2'b11:   code = 8'd255;
            2'b01:   code = 8'd127;
            2'b10:   code = 8'd63;
            default: code = 8'd7;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/ofs_default_sel.sv
module ofs_default_sel
    import ofs_serial_port_pkg::*;
#(
    parameter int W = 14
) (
    input  logic [1:0]   sel,
    output logic [W-1:0] dflt
);
    logic [7:0] code;

    assign code = dflt_code(sel);

    generate
        if (W >= 8) begin : g_wide
            assign dflt = W'(code);
        end else begin : g_narrow
            // A narrow offset saturates to its maximum representable value.
            always_comb begin
                if (code > 8'((1 << W) - 1)) dflt = '1;
                else                         dflt = code[W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/ofs_load_fsm.sv
module ofs_load_fsm
    import ofs_serial_port_pkg::*;
#(
    parameter int W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           ser_in,
    input  logic [W-1:0]   dflt,
    output logic [2*W-1:0] act_chain,
    output logic           valid
);
    localparam int L  = 2 * W;
    localparam int CW = $clog2(L);
    localparam logic [CW-1:0] LAST = CW'(L - 1);

    ld_state_t     st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [L-1:0]  stage, stage_nx;
    logic          commit;

    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        stage_nx = stage;
        commit   = 1'b0;
        if (shift_en) begin
            stage_nx = {ser_in, stage[L-1:1]};
            unique case (st)
                LD_ARMED: begin
                    cnt_nx = CW'(1);
                    st_nx  = LD_FILLING;
                end
                LD_FILLING: begin
                    if (cnt == LAST) begin
                        cnt_nx = '0;
                        st_nx  = LD_ARMED;
                        commit = 1'b1;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LD_ARMED;
            cnt   <= '0;
            stage <= '0;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            stage <= stage_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      act_chain <= {dflt, dflt};
        else if (commit) act_chain <= stage_nx;
    end

    assign valid = (st == LD_ARMED);
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_serial_port_pkg::*;
#(
    parameter int L = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [L-1:0] chain,
    output logic         ser_out
);
    localparam int IW = $clog2(L);
    localparam logic [IW-1:0] LAST = IW'(L - 1);

    rb_state_t     rb, rb_nx;
    logic [IW-1:0] idx, idx_sel;

    always_comb begin
        rb_nx = rd_en ? RB_STREAM : RB_IDLE;
        unique case (rb)
            RB_IDLE:   idx_sel = '0;
            RB_STREAM: idx_sel = idx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb <= RB_IDLE;
        else        rb <= rb_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            ser_out <= 1'b0;
        end else if (rd_en) begin
            ser_out <= chain[idx_sel];
            idx     <= (idx_sel == LAST) ? '0 : idx_sel + IW'(1);
        end
    end
endmodule

// File: rtl/ofs_serial_port.sv
module ofs_serial_port
    import ofs_serial_port_pkg::*;
#(
    parameter int DEPTH = 16384,
    parameter int W     = $clog2(DEPTH)
) (
    input  logic         shift_clk,
    input  logic         rst_n,
    input  logic [1:0]   dflt_sel,
    input  logic         load_n,
    input  logic         ser_in,
    input  logic         rdbk_n,
    output logic         ser_out,
    output logic [W-1:0] empty_ofs,
    output logic [W-1:0] full_ofs,
    output logic         ofs_valid
);
    localparam int L = 2 * W;

    logic           do_load;
    logic           do_read;
    logic [W-1:0]   dflt;
    logic [L-1:0]   chain;

    // A conflict (both enables low) selects neither operation.
    assign do_load = !load_n &&  rdbk_n;
    assign do_read =  load_n && !rdbk_n;

    ofs_default_sel #(.W(W)) u_dflt (
        .sel  (dflt_sel),
        .dflt (dflt)
    );

    ofs_load_fsm #(.W(W)) u_load (
        .clk       (shift_clk),
        .rst_n     (rst_n),
        .shift_en  (do_load),
        .ser_in    (ser_in),
        .dflt      (dflt),
        .act_chain (chain),
        .valid     (ofs_valid)
    );

    ofs_readback #(.L(L)) u_rdbk (
        .clk     (shift_clk),
        .rst_n   (rst_n),
        .rd_en   (do_read),
        .chain   (chain),
        .ser_out (ser_out)
    );

    assign empty_ofs = chain[W-1:0];
    assign full_ofs  = chain[L-1:W];
endmodule

// File: rtl/ofs_serial_port_chk.sv
module ofs_serial_port_chk #(
    parameter int W = 14
) (
    input logic         shift_clk,
    input logic         rst_n,
    input logic         load_n,
    input logic         rdbk_n,
    input logic         ser_out,
    input logic [W-1:0] empty_ofs,
    input logic [W-1:0] full_ofs,
    input logic         ofs_valid
);
    assert_partial_hold_R4: assert property (@(posedge shift_clk) disable iff (!rst_n)
        !ofs_valid |-> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_open_chain_R3: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (!load_n && rdbk_n && ofs_valid) |=> !ofs_valid);

    assert_conflict_noop_R8: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (!load_n && !rdbk_n) |=> ($stable(ser_out) && $stable(ofs_valid)
                                  && $stable(empty_ofs) && $stable(full_ofs)));

    assert_read_no_touch_R6: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (load_n && !rdbk_n) |=> ($stable(ofs_valid) && $stable(empty_ofs) && $stable(full_ofs)));

    assert_idle_hold_R7: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (load_n && rdbk_n) |=> ($stable(ser_out) && $stable(ofs_valid)
                                && $stable(empty_ofs) && $stable(full_ofs)));
endmodule

bind ofs_serial_port ofs_serial_port_chk #(.W(W)) u_chk (
    .shift_clk (shift_clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .rdbk_n    (rdbk_n),
    .ser_out   (ser_out),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .ofs_valid (ofs_valid)
);

// File: tb/ofs_serial_port_bench.sv
module ofs_serial_port_bench;
    localparam int DEPTH = 16384;
    localparam int W     = $clog2(DEPTH);
    localparam int L     = 2 * W;

    logic         shift_clk = 1'b0;
    logic         rst_n     = 1'b0;
    logic [1:0]   dflt_sel  = 2'b00;
    logic         load_n    = 1'b1;
    logic         ser_in    = 1'b0;
    logic         rdbk_n    = 1'b1;
    logic         ser_out;
    logic [W-1:0] empty_ofs;
    logic [W-1:0] full_ofs;
    logic         ofs_valid;

    int total = 0;
    int bad   = 0;

    // Bench model state, built from the requirements.
    logic [L-1:0] m_act;
    logic [L-1:0] m_stage;
    int           m_cnt;
    bit           m_valid;
    bit           m_rdon;
    int           m_idx;
    bit           m_so;

    always #2 shift_clk = ~shift_clk;

    ofs_serial_port #(.DEPTH(DEPTH)) u_ofs_serial_port (
        .shift_clk (shift_clk),
        .rst_n     (rst_n),
        .dflt_sel  (dflt_sel),
        .load_n    (load_n),
        .ser_in    (ser_in),
        .rdbk_n    (rdbk_n),
        .ser_out   (ser_out),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .ofs_valid (ofs_valid)
    );

    function automatic logic [W-1:0] dflt_of(input logic [1:0] s);
        case (s)
            2'b11:   return W'(255);
            2'b01:   return W'(127);
            2'b10:   return W'(63);
            default: return W'(7);
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "ofs_valid", 32'(ofs_valid), 32'(m_valid));
        check(tag, "empty_ofs", 32'(empty_ofs), 32'(m_act[W-1:0]));
        check(tag, "full_ofs",  32'(full_ofs),  32'(m_act[L-1:W]));
        check(tag, "ser_out",   32'(ser_out),   32'(m_so));
    endtask

    task automatic do_reset(input logic [1:0] s, input string tag);
        @(negedge shift_clk);
        rst_n = 1'b0; dflt_sel = s; load_n = 1'b1; rdbk_n = 1'b1;
        @(posedge shift_clk); @(posedge shift_clk);
        @(negedge shift_clk);
        rst_n   = 1'b1;
        m_act   = {dflt_of(s), dflt_of(s)};
        m_cnt   = 0;
        m_valid = 1'b1;
        m_rdon  = 1'b0;
        m_idx   = 0;
        m_so    = 1'b0;
        check_all(tag);
    endtask

    task automatic step(input bit ld_n, input bit rd_n, input bit si, input string tag);
        @(negedge shift_clk);
        load_n = ld_n; rdbk_n = rd_n; ser_in = si;
        @(posedge shift_clk);
        #1;
        if (!ld_n && rd_n) begin
            m_stage = {si, m_stage[L-1:1]};
            if (m_cnt == L - 1) begin
                m_act   = m_stage;
                m_cnt   = 0;
                m_valid = 1'b1;
            end else begin
                m_cnt++;
                m_valid = 1'b0;
            end
        end
        if (ld_n && !rd_n) begin
            int k;
            k      = m_rdon ? m_idx : 0;
            m_so   = m_act[k];
            m_idx  = (k + 1) % L;
            m_rdon = 1'b1;
        end else begin
            m_rdon = 1'b0;
        end
        check_all(tag);
    endtask

    task automatic load_chain(input logic [W-1:0] e, input logic [W-1:0] f, input string tag);
        logic [L-1:0] c;
        c = {f, e};
        for (int i = 0; i < L; i++) step(1'b0, 1'b1, c[i], tag);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        m_stage = '0;

        // R1: every default select value
        do_reset(2'b11, "R1");
        do_reset(2'b01, "R1");
        do_reset(2'b10, "R1");
        do_reset(2'b00, "R1");
        check("R1", "empty default 7", 32'(empty_ofs), 32'd7);

        // R2 / R3: one full chain with a known pattern
        step(1'b0, 1'b1, 1'b1, "R3");
        check("R3", "valid after first bit", 32'(ofs_valid), 32'd0);
        do_reset(2'b00, "R1");
        load_chain(14'h1A5B, 14'h0C3D, "R2");
        check("R2", "empty value", 32'(empty_ofs), 32'h1A5B);
        check("R2", "full value",  32'(full_ofs),  32'h0C3D);
        check("R3", "valid at commit", 32'(ofs_valid), 32'd1);

        // R4 / R7: partial load, readback of old values, resume
        for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 1'(i), "R4");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R7");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R7");
        for (int i = 9; i < L; i++) step(1'b0, 1'b1, 1'(i >> 1), "R4");

        // R8: conflict edges mid-chain and mid-readback
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R8");
        for (int i = 5; i < L; i++) step(1'b0, 1'b1, 1'b0, "R8");
        check("R8", "valid after resumed chain", 32'(ofs_valid), 32'd1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b0, "R7");

        // R10: extreme values, then R9 wrap-around readback
        load_chain(14'h0000, 14'h3FFF, "R10");
        check("R10", "empty zero", 32'(empty_ofs), 32'h0);
        check("R10", "full max",   32'(full_ofs),  32'h3FFF);
        step(1'b1, 1'b1, 1'b0, "R7");
        for (int i = 0; i < 2 * L + 3; i++) step(1'b1, 1'b0, 1'b0, "R9");
        load_chain(14'h3FFF, 14'h0000, "R10");
        check("R10", "empty max", 32'(empty_ofs), 32'h3FFF);

        // R5: random mix of loads, reads, idles and conflicts
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 5)      step(1'b0, 1'b1, 1'($urandom_range(0, 1)), "R5");
            else if (r < 8) step(1'b1, 1'b0, 1'b0, "R6");
            else if (r < 9) step(1'b1, 1'b1, 1'b0, "R7");
            else            step(1'b0, 1'b0, 1'($urandom_range(0, 1)), "R8");
        end

        do_reset(2'b10, "R1");
        check("R1", "full default 63", 32'(full_ofs), 32'd63);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule